// File: doc/BRIEF.md
# External Interrupt Controller Register Bank

This block holds the configuration and status state of a multi-channel external interrupt controller, behind a single-cycle memory-mapped register port. For each channel it stores two configuration bits: trigger kind and active sense. It drives these bits out to a separate detection block. That detection block returns one trigger pulse per channel whenever its condition is met.

Two independent gates act on every channel. The channel-enable layer decides whether a trigger can set the sticky status bit at all. The interrupt-mask layer only decides whether a set status bit is forwarded to the processor interrupt line. A channel can therefore be enabled but masked: it still records status and still raises the wake output, but it does not interrupt the processor. Both layers are written through separate set and clear addresses, so software never needs a read-modify-write sequence.

Top module: `xint_ctrl`

Register map (word addresses on `addr_i`): 0 trigger kind (rw), 1 sense (rw), 2 mask set (w), 3 mask clear (w), 4 mask (r), 5 channel enable (w), 6 channel disable (w), 7 channel control (r), 8 status (r), 9 status clear (w). Channel n uses data bit n.

## Requirements
- R1: After reset, every register reads 0, and irq_o and wake_o are 0.
- R2: Addresses 0 and 1 are read/write and drive trig_type_o and polarity_o. In the trigger-kind bit, 0 means edge and 1 means level. In the sense bit, 0 means falling edge or low level, and 1 means rising edge or high level.
- R3: Writing 1 to a bit at address 2 sets that mask bit, and writing 1 at address 3 clears it. Zero bits leave the mask unchanged. The mask reads back at address 4.
- R4: Writing 1 to a bit at address 5 enables that channel, and writing 1 at address 6 disables it. Zero bits have no effect. The channel control register reads back at address 7.
- R5: A trigger pulse on an enabled channel sets its status bit (address 8). The bit stays set until 1 is written to that bit at address 9. Zero bits written at address 9 have no effect.
- R6: A trigger on a disabled channel is ignored, and a disabled channel's status bit always reads 0.
- R7: Disabling a channel clears its status bit, even when a trigger for that channel arrives in the same cycle.
- R8: Clearing a channel's mask bit also clears its status bit.
- R9: If a trigger and a status-clear write hit the same channel in the same cycle, the status bit stays set.
- R10: irq_o is 1 exactly when some channel has both its status bit and its mask bit set. wake_o is 1 whenever any status bit is set, whether or not the channel is masked.
- R11: rdata_o presents the selected register in the cycle after re_i. Write-only and unmapped addresses read 0.
- R12: Write data bits at and above NCH are ignored and always read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register word address |
| wdata_i | input | DW | Write data |
| we_i | input | 1 | Write strobe, one cycle per access |
| re_i | input | 1 | Read strobe, one cycle per access |
| rdata_o | output | DW | Read data, registered |
| trig_i | input | NCH | Per-channel trigger pulses from the detection block |
| trig_type_o | output | NCH | Per-channel trigger kind (0 edge, 1 level) |
| polarity_o | output | NCH | Per-channel sense (0 falling/low, 1 rising/high) |
| irq_o | output | 1 | Combined processor interrupt |
| wake_o | output | 1 | Wake request, OR of all status bits |

## Verification
A stuck or wrongly updated status bit shows on wake_o in the cycle after the trigger or write that caused it. It also shows on irq_o in that cycle whenever the channel is unmasked. A lost or spurious mask or enable bit appears on the next read of address 4 or 7, one cycle after the read strobe. The enable layer can also reveal it indirectly, when a later trigger fails to set status or sets status it should not. The bench therefore drives triggers together with clear, disable and mask-clear writes in the same cycle, and it observes both the register readback and the two outputs.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int unsigned AW = 4;

  typedef enum logic [AW-1:0] {
    A_TYPE = 4'd0,
    A_POL  = 4'd1,
    A_MSET = 4'd2,
    A_MCLR = 4'd3,
    A_MASK = 4'd4,
    A_CEN  = 4'd5,
    A_CDIS = 4'd6,
    A_CTRL = 4'd7,
    A_STAT = 4'd8,
    A_SCLR = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/xint_cfg_reg.sv
module xint_cfg_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/xint_setclr_reg.sv
module xint_setclr_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/xint_status.sv
module xint_status #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] kill_i,  // disable or mask clear: beats trigger
  input  logic [N-1:0] clr_i,   // w1c: loses to trigger
  output logic [N-1:0] stat_o
);
  logic [N-1:0] hit, keep;

  always_comb begin
    hit  = trig_i & en_i & ~kill_i;
    keep = stat_o & en_i & ~kill_i & ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= hit | keep;
  end
endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           we_i,
  input  logic           re_i,
  output logic [DW-1:0]  rdata_o,
  input  logic [NCH-1:0] trig_i,
  output logic [NCH-1:0] trig_type_o,
  output logic [NCH-1:0] polarity_o,
  output logic           irq_o,
  output logic           wake_o
);
  localparam int unsigned PAD = DW - NCH;

  logic [NCH-1:0] wbits;
  logic [NCH-1:0] mset_m, mclr_m, cen_m, cdis_m, sclr_m, kill_m;
  logic [NCH-1:0] mask_q, en_q, stat_q;
  logic           ld_type, ld_pol;
  logic [NCH-1:0] rd_sel;

  assign wbits = wdata_i[NCH-1:0];

  generate
    if (PAD > 0) begin : g_unused
      logic unused_hi;
      assign unused_hi = ^wdata_i[DW-1:NCH];
    end
  endgenerate

  always_comb begin
    ld_type = we_i && (addr_i == A_TYPE);
    ld_pol  = we_i && (addr_i == A_POL);
    mset_m  = (we_i && addr_i == A_MSET) ? wbits : '0;
    mclr_m  = (we_i && addr_i == A_MCLR) ? wbits : '0;
    cen_m   = (we_i && addr_i == A_CEN)  ? wbits : '0;
    cdis_m  = (we_i && addr_i == A_CDIS) ? wbits : '0;
    sclr_m  = (we_i && addr_i == A_SCLR) ? wbits : '0;
    kill_m  = cdis_m | mclr_m;
  end

  xint_cfg_reg #(.N(NCH)) u_type (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld_type), .d_i(wbits), .q_o(trig_type_o)
  );

  xint_cfg_reg #(.N(NCH)) u_pol (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld_pol), .d_i(wbits), .q_o(polarity_o)
  );

  xint_setclr_reg #(.N(NCH)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(mset_m), .clr_i(mclr_m), .q_o(mask_q)
  );

  xint_setclr_reg #(.N(NCH)) u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(cen_m), .clr_i(cdis_m), .q_o(en_q)
  );

  xint_status #(.N(NCH)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .en_i(en_q),
    .kill_i(kill_m), .clr_i(sclr_m), .stat_o(stat_q)
  );

  always_comb begin
    unique case (addr_i)
      A_TYPE:  rd_sel = trig_type_o;
      A_POL:   rd_sel = polarity_o;
      A_MASK:  rd_sel = mask_q;
      A_CTRL:  rd_sel = en_q;
      A_STAT:  rd_sel = stat_q;
      default: rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= DW'(rd_sel);
  end

  assign irq_o  = |(stat_q & mask_q);
  assign wake_o = |stat_q;
endmodule

// File: rtl/xint_ctrl_chk.sv
module xint_ctrl_chk
  import xint_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned DW  = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [AW-1:0]  addr_i,
  input logic [DW-1:0]  wdata_i,
  input logic           we_i,
  input logic           re_i,
  input logic [DW-1:0]  rdata_o,
  input logic [NCH-1:0] trig_i,
  input logic           irq_o,
  input logic           wake_o,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] mask_q,
  input logic [NCH-1:0] stat_q
);
  logic [NCH-1:0] c_dis, c_mclr, c_mset, c_live;

  assign c_dis  = (we_i && addr_i == A_CDIS) ? wdata_i[NCH-1:0] : '0;
  assign c_mclr = (we_i && addr_i == A_MCLR) ? wdata_i[NCH-1:0] : '0;
  assign c_mset = (we_i && addr_i == A_MSET) ? wdata_i[NCH-1:0] : '0;
  assign c_live = trig_i & en_q & ~c_dis & ~c_mclr;

  // R6
  stat_only_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~en_q) == '0);

  // R7
  dis_clears_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_dis != '0) |=> ((stat_q & $past(c_dis)) == '0));

  // R8
  mclr_clears_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_mclr != '0) |=> ((stat_q & $past(c_mclr)) == '0));

  // R9
  trig_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_live != '0) |=> ((~stat_q & $past(c_live)) == '0));

  // R3
  mset_sets_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_mset != '0) |=> ((~mask_q & $past(c_mset)) == '0));

  // R10
  irq_implies_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wake_o);

  // R11
  unmapped_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i > A_SCLR) |=> (rdata_o == '0));
endmodule

bind xint_ctrl xint_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .trig_i(trig_i),
  .irq_o(irq_o), .wake_o(wake_o), .en_q(en_q), .mask_q(mask_q), .stat_q(stat_q)
);

// File: tb/xint_ctrl_tb_top.sv
`timescale 1ns/1ps
module xint_ctrl_tb_top;
  localparam int NCH = 8;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [3:0]     addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic           we = 1'b0, re = 1'b0;
  logic [DW-1:0]  rdata;
  logic [NCH-1:0] trig = '0;
  logic [NCH-1:0] ttype, pol;
  logic           irq, wake;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [DW-1:0] q_exp[$];
  string         q_tag[$];

  always #2.5 clk = ~clk;

  xint_ctrl #(.NCH(NCH), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .re_i(re), .rdata_o(rdata), .trig_i(trig), .trig_type_o(ttype),
    .polarity_o(pol), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: a read strobe seen at an edge is compared at the next negedge
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && re) begin
        @(negedge clk);
        if (q_exp.size() == 0) chk("scoreboard underflow", 1, 0);
        else chk(q_tag.pop_front(), rdata, q_exp.pop_front());
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [DW-1:0] d,
                    input logic [NCH-1:0] t = '0);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; trig = t;
    @(negedge clk);
    we = 1'b0; trig = '0; wdata = '0;
  endtask

  task automatic pulse(input logic [NCH-1:0] t);
    @(negedge clk);
    trig = t;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    addr = a; re = 1'b1;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic outs(input logic i, input logic w, input string tag);
    chk({tag, " irq"},  DW'(irq),  DW'(i));
    chk({tag, " wake"}, DW'(wake), DW'(w));
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    outs(0, 0, "R1 reset");
    for (int a = 0; a < 10; a++) rd(4'(a), 0, "R1 reset reg");

    wr(0, 32'h0000_00A5); rd(0, 32'hA5, "R2 type rd");
    chk("R2 trig_type_o", DW'(ttype), 32'hA5);
    wr(1, 32'h0000_003C); rd(1, 32'h3C, "R2 pol rd");
    chk("R2 polarity_o", DW'(pol), 32'h3C);
    wr(0, 32'hFFFF_FF00); rd(0, 32'h0, "R12 high bits");

    wr(2, 32'h0F); rd(4, 32'h0F, "R3 mset");
    wr(2, 32'h00); rd(4, 32'h0F, "R3 zero write");
    wr(3, 32'h03); rd(4, 32'h0C, "R3 mclr");

    wr(5, 32'h33); rd(7, 32'h33, "R4 enable");
    wr(6, 32'h00); rd(7, 32'h33, "R4 zero disable");

    pulse(8'hFF);
    rd(8, 32'h33, "R5 status set");
    outs(0, 1, "R10 enabled masked");
    wr(2, 32'h01);
    outs(1, 1, "R10 unmasked");

    wr(9, 32'h10); rd(8, 32'h23, "R5 clear");
    wr(9, 32'h00); rd(8, 32'h23, "R5 zero clear");

    wr(9, 32'h02, 8'h02); rd(8, 32'h23, "R9 trig beats clear");

    pulse(8'h80); rd(8, 32'h23, "R6 disabled trig");

    wr(6, 32'h20); rd(8, 32'h03, "R7 disable clears");
    wr(6, 32'h01, 8'h01); rd(8, 32'h02, "R7 disable beats trig");
    rd(7, 32'h12, "R4 ctrl after disable");
    outs(0, 1, "R10 mask miss");

    wr(2, 32'h02); outs(1, 1, "R10 irq ch1");
    wr(3, 32'h02); rd(8, 32'h00, "R8 mclr clears");
    rd(4, 32'h0D, "R3 mask after clr");
    outs(0, 0, "R8 idle");

    rd(15, 32'h0, "R11 unmapped");
    rd(2, 32'h0, "R11 write-only");
    rd(9, 32'h0, "R11 sclr read");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule